// File: doc/BRIEF.md
# Activation-Counting Targeted Row Refresh Tracker

This block sits beside a memory controller and watches every row activate command it sends to a multi-bank DRAM. Each bank has its own small table of recently activated rows with a count per row. The counts run inside a fixed refresh window and are wiped when that window closes. A row whose count passes a configurable maximum becomes an aggressor. Its two physical neighbours become victims that need an extra refresh before their charge is disturbed.

Aggressors are not serviced at once. Each one waits in a short queue. Each periodic refresh strobe from the controller takes at most one waiting aggressor from that queue. The block then emits the victim rows as two consecutive request slots, the row below first and the row above second, so that they ride along with the regular refresh.

When a bank's table is full, a newly seen row takes over the entry with the smallest count. When the queue is full, a new aggressor is dropped and an overflow pulse is raised. The window length, threshold, table size, queue depth and address widths are all parameters, so a scaled-down configuration can be used for checking.

Top module: `act_tracker_trr`

## Requirements
- R1: After reset, `trr_valid` and `overflow` are low and stay low until an aggressor has been queued and a refresh strobe has taken it.
- R2: The (ACT_MAX+1)-th activation of a row within one window queues that row. After the next refresh strobe, the first slot gives row N-1 and the second slot gives row N+1, both with the aggressor's bank.
- R3: A row activated no more than ACT_MAX times within a window queues nothing, and a later refresh strobe yields no request.
- R4: Each bank keeps its own counts. Activations of the same row number in other banks never add to a bank's count.
- R5: When the window of WINDOW_CYC cycles ends, all counts clear. An activation made on the cycle the window ends is ignored.
- R6: Victims are clamped at the array edges. Row 0 yields only row 1, in the second slot. The top row, 2^ROW_W-1, yields only the row below it, in the first slot.
- R7: Once an aggressor is queued, its count restarts from zero. 2*(ACT_MAX+1) activations of a row therefore queue it twice.
- R8: Each refresh strobe takes at most one queued aggressor, in arrival order. A strobe with an empty queue yields nothing. A strobe that arrives while a pair is still being emitted is ignored.
- R9: When QDEPTH aggressors are already waiting and another one is found, the new one is dropped and never emitted. `overflow` pulses high for one cycle, in the cycle after the activation that was dropped.
- R10: When a row misses in a full bank table, it replaces the valid entry with the lowest count (the lowest index wins a tie) and starts at a count of one. The replaced row loses its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | A row activate command is issued this cycle |
| act_bank | input | BANK_W | Bank of the activate |
| act_row | input | ROW_W | Row of the activate |
| ref_strobe | input | 1 | Periodic refresh command slot |
| trr_valid | output | 1 | A victim-row refresh request is present |
| trr_bank | output | BANK_W | Bank of the victim row |
| trr_row | output | ROW_W | Victim row to refresh |
| overflow | output | 1 | One-cycle pulse when an aggressor is dropped because the queue is full |

## Verification
An aggressor is queued at the clock edge that samples its triggering activation, and `overflow` for a dropped aggressor is visible in the cycle after that edge. A refresh strobe sampled at edge k puts the lower victim on the outputs between edges k and k+1, and the upper victim between edges k+1 and k+2. The bench drives every input at the falling edge and reads the outputs at the falling edges that fall inside those windows. Window timing is derived from a bench count of rising edges since reset. Bursts are placed clear of a window boundary, except in the test that deliberately crosses one.

// File: rtl/trr_pkg.sv
package trr_pkg;
  // phases of the victim-pair drain sequence
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2
  } drain_ph_t;
endpackage

// File: rtl/trr_window_timer.sv
module trr_window_timer #(
  parameter int WINDOW_CYC = 6400000
) (
  input  logic clk,
  input  logic rst_n,
  output logic win_end
);
  localparam int TW = (WINDOW_CYC > 1) ? $clog2(WINDOW_CYC) : 1;

  logic [TW-1:0] tick;

  assign win_end = (tick == TW'(WINDOW_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tick <= '0;
    else if (win_end) tick <= '0;
    else              tick <= tick + 1'b1;
  end

  // R5: the window counter never leaves its range
  a_r5_tick_range: assert property (@(posedge clk) disable iff (!rst_n)
    tick <= TW'(WINDOW_CYC - 1));
endmodule

// File: rtl/trr_bank_table.sv
module trr_bank_table #(
  parameter int ENTRIES = 8,
  parameter int ROW_W   = 16,
  parameter int CNT_W   = 16,
  parameter int ACT_MAX = 20000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic             act_en,
  input  logic [ROW_W-1:0] act_row,
  output logic             trig
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld;
  logic [ROW_W-1:0]   tag [ENTRIES];
  logic [CNT_W-1:0]   cnt [ENTRIES];
  logic [ENTRIES-1:0] hit_vec;
  logic               any_hit;
  logic [IW-1:0]      hit_idx;
  logic [IW-1:0]      new_idx;

  // lowest set bit of a vector
  function automatic logic [IW-1:0] first_set(input logic [ENTRIES-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) if (v[i]) r = IW'(i);
    return r;
  endfunction

  // a free slot if there is one, otherwise the lowest count (lowest index on a tie)
  function automatic logic [IW-1:0] pick_slot(input logic [ENTRIES-1:0] v,
                                              input logic [CNT_W-1:0] c [ENTRIES]);
    logic [IW-1:0]    best;
    logic [CNT_W-1:0] bc;
    best = '0;
    bc   = c[0];
    for (int i = 1; i < ENTRIES; i++) begin
      if (c[i] < bc) begin
        bc   = c[i];
        best = IW'(i);
      end
    end
    if (!(&v)) best = first_set(~v);
    return best;
  endfunction

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) hit_vec[i] = vld[i] && (tag[i] == act_row);
  end

  assign any_hit = |hit_vec;
  assign hit_idx = first_set(hit_vec);
  assign new_idx = pick_slot(vld, cnt);
  // count after this activation would exceed the maximum
  assign trig    = act_en && any_hit && (cnt[hit_idx] >= CNT_W'(ACT_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i] <= '0;
        cnt[i] <= '0;
      end
    end else if (win_end) begin
      vld <= '0;
    end else if (act_en) begin
      if (any_hit) begin
        cnt[hit_idx] <= trig ? '0 : cnt[hit_idx] + 1'b1;
      end else begin
        vld[new_idx] <= 1'b1;
        tag[new_idx] <= act_row;
        cnt[new_idx] <= CNT_W'(1);
      end
    end
  end

  // R5: a window end leaves every entry empty
  a_r5_window_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $past(win_end) |-> (vld == '0));

  // R7: a live counter never goes past the maximum, because a trigger restarts it
  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cnt_chk
      a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        vld[g] |-> (cnt[g] <= CNT_W'(ACT_MAX)));
    end
  endgenerate

  // R10: a tag is never held twice
  a_r10_unique_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: rtl/trr_victim_fifo.sv
module trr_victim_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 19
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [LW-1:0] level;
  logic          full, do_pop, accept;

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (level == LW'(DEPTH));
  assign empty  = (level == '0);
  assign do_pop = pop && !empty;
  assign accept = push && (!full || do_pop);
  assign head   = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
      drop   <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      drop <= push && !accept;
      if (accept) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= next_ptr(wr_ptr);
      end
      if (do_pop) rd_ptr <= next_ptr(rd_ptr);
      if (accept && !do_pop)      level <= level + 1'b1;
      else if (do_pop && !accept) level <= level - 1'b1;
    end
  end

  // R8: a pop without a push lowers the level by exactly one
  a_r8_pop_advances: assert property (@(posedge clk) disable iff (!rst_n)
    $past(do_pop && !accept) |-> ((level + 1'b1) == $past(level)));

  // R9: a dropped aggressor leaves the queue still holding entries
  a_r9_drop_when_occupied: assert property (@(posedge clk) disable iff (!rst_n)
    drop |-> !empty);
endmodule

// File: rtl/trr_drain_seq.sv
module trr_drain_seq
  import trr_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_strobe,
  input  logic              q_empty,
  input  logic [BANK_W-1:0] q_bank,
  input  logic [ROW_W-1:0]  q_row,
  output logic              pop,
  output logic              trr_valid,
  output logic [BANK_W-1:0] trr_bank,
  output logic [ROW_W-1:0]  trr_row
);
  drain_ph_t         ph;
  logic [BANK_W-1:0] d_bank;
  logic [ROW_W-1:0]  d_row;

  function automatic logic has_below(input logic [ROW_W-1:0] r);
    return r != '0;
  endfunction
  function automatic logic has_above(input logic [ROW_W-1:0] r);
    return r != '1;
  endfunction

  assign pop = ref_strobe && !q_empty && (ph == PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      d_bank <= '0;
      d_row  <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (pop) begin
          ph     <= PH_LO;
          d_bank <= q_bank;
          d_row  <= q_row;
        end
        PH_LO:   ph <= PH_HI;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    trr_bank = d_bank;
    case (ph)
      PH_LO: begin
        trr_valid = has_below(d_row);
        trr_row   = d_row - 1'b1;
      end
      PH_HI: begin
        trr_valid = has_above(d_row);
        trr_row   = d_row + 1'b1;
      end
      default: begin
        trr_valid = 1'b0;
        trr_row   = '0;
      end
    endcase
  end

  // R8: the lower slot only ever follows a refresh strobe
  a_r8_slot_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_LO) |-> $past(ref_strobe));

  // R6: the upper victim never wraps to row 0 and the lower never wraps to the top
  a_r6_upper_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (trr_valid && ph == PH_HI) |-> (trr_row != '0));
  a_r6_lower_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (trr_valid && ph == PH_LO) |-> (trr_row != '1));

  // R2: both slots of a pair name the same bank
  a_r2_pair_same_bank: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_HI) |-> $stable(trr_bank));
endmodule

// File: rtl/act_tracker_trr.sv
module act_tracker_trr #(
  parameter int NUM_BANKS  = 8,
  parameter int ROW_W      = 16,
  parameter int ENTRIES    = 8,
  parameter int CNT_W      = 16,
  parameter int ACT_MAX    = 20000,
  parameter int WINDOW_CYC = 6400000,
  parameter int QDEPTH     = 8,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_valid,
  input  logic [BANK_W-1:0] act_bank,
  input  logic [ROW_W-1:0]  act_row,
  input  logic              ref_strobe,
  output logic              trr_valid,
  output logic [BANK_W-1:0] trr_bank,
  output logic [ROW_W-1:0]  trr_row,
  output logic              overflow
);
  localparam int QW = BANK_W + ROW_W;

  logic                 win_end;
  logic [NUM_BANKS-1:0] trig_vec;
  logic                 push, pop, q_empty;
  logic [QW-1:0]        q_head;

  trr_window_timer #(.WINDOW_CYC(WINDOW_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .win_end(win_end)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic bank_en;
      assign bank_en = act_valid && (act_bank == BANK_W'(b)) && !win_end;
      trr_bank_table #(
        .ENTRIES(ENTRIES), .ROW_W(ROW_W), .CNT_W(CNT_W), .ACT_MAX(ACT_MAX)
      ) u_table (
        .clk(clk), .rst_n(rst_n), .win_end(win_end),
        .act_en(bank_en), .act_row(act_row), .trig(trig_vec[b])
      );
    end
  endgenerate

  assign push = |trig_vec;

  trr_victim_fifo #(.DEPTH(QDEPTH), .DW(QW)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data({act_bank, act_row}),
    .pop(pop), .head(q_head), .empty(q_empty), .drop(overflow)
  );

  trr_drain_seq #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_drain (
    .clk(clk), .rst_n(rst_n), .ref_strobe(ref_strobe), .q_empty(q_empty),
    .q_bank(q_head[QW-1:ROW_W]), .q_row(q_head[ROW_W-1:0]), .pop(pop),
    .trr_valid(trr_valid), .trr_bank(trr_bank), .trr_row(trr_row)
  );

  // R4: only the addressed bank can raise a trigger
  a_r4_one_bank_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(trig_vec));
  a_r4_trig_in_addressed_bank: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (act_valid && trig_vec[act_bank]));

  // R5: an activation in the window-end cycle never triggers
  a_r5_no_trig_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> !push);

  // R9: an overflow pulse lasts a single cycle unless a new trigger arrives
  a_r9_overflow_follows_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(push));
endmodule

// File: tb/sim_act_tracker_trr.sv
module sim_act_tracker_trr;
  localparam int CLK_PERIOD = 10;
  localparam int NB  = 4;
  localparam int RW  = 6;
  localparam int AM  = 3;
  localparam int WIN = 400;
  localparam int MARGIN = 64;

  typedef struct packed {
    logic [1:0] bank;
    logic [5:0] row;
    logic [3:0] reps;
    logic       lo_v;
    logic [5:0] lo;
    logic       hi_v;
    logic [5:0] hi;
  } vec_t;

  // bank, row, activations, lower victim, upper victim
  localparam vec_t VECS [5] = '{
    '{2'd0, 6'd10, 4'd4, 1'b1, 6'd9,  1'b1, 6'd11},  // R2
    '{2'd1, 6'd20, 4'd3, 1'b0, 6'd0,  1'b0, 6'd0 },  // R3
    '{2'd2, 6'd0,  4'd4, 1'b0, 6'd0,  1'b1, 6'd1 },  // R6 bottom edge
    '{2'd3, 6'd63, 4'd4, 1'b1, 6'd62, 1'b0, 6'd0 },  // R6 top edge
    '{2'd0, 6'd40, 4'd4, 1'b1, 6'd39, 1'b1, 6'd41}   // R2
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic act_valid = 1'b0;
  logic [1:0] act_bank = '0;
  logic [RW-1:0] act_row = '0;
  logic ref_strobe = 1'b0;
  logic trr_valid;
  logic [1:0] trr_bank;
  logic [RW-1:0] trr_row;
  logic overflow;

  int checks = 0;
  int errors = 0;
  int ncyc = 0;
  bit ovf_seen = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) if (rst_n) ncyc <= ncyc + 1;

  act_tracker_trr #(
    .NUM_BANKS(NB), .ROW_W(RW), .ENTRIES(4), .CNT_W(8),
    .ACT_MAX(AM), .WINDOW_CYC(WIN), .QDEPTH(2)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_bank(act_bank),
    .act_row(act_row), .ref_strobe(ref_strobe), .trr_valid(trr_valid),
    .trr_bank(trr_bank), .trr_row(trr_row), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hammer(input int b, input int r, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      ovf_seen |= overflow;
      act_valid = 1'b1;
      act_bank  = 2'(b);
      act_row   = RW'(r);
    end
    @(negedge clk);
    ovf_seen |= overflow;
    act_valid = 1'b0;
  endtask

  task automatic refresh_expect(input string req, input int b,
                                input bit lo_v, input int lo, input bit hi_v, input int hi);
    @(negedge clk);
    ref_strobe = 1'b1;
    @(negedge clk);
    ref_strobe = 1'b0;
    chk(trr_valid == lo_v, {req, " lower slot valid"}, trr_valid, lo_v);
    if (lo_v) begin
      chk(trr_row == RW'(lo), {req, " lower row"}, trr_row, lo);
      chk(trr_bank == 2'(b), {req, " lower bank"}, trr_bank, b);
    end
    @(negedge clk);
    chk(trr_valid == hi_v, {req, " upper slot valid"}, trr_valid, hi_v);
    if (hi_v) begin
      chk(trr_row == RW'(hi), {req, " upper row"}, trr_row, hi);
      chk(trr_bank == 2'(b), {req, " upper bank"}, trr_bank, b);
    end
    @(negedge clk);
    chk(trr_valid == 1'b0, {req, " idle after pair"}, trr_valid, 0);
  endtask

  task automatic avoid_boundary();
    while ((ncyc % WIN) >= (WIN - MARGIN)) @(negedge clk);
  endtask

  task automatic next_window();
    int target;
    target = ((ncyc / WIN) + 1) * WIN + 5;
    while (ncyc < target) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: quiet after reset
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(trr_valid == 1'b0, "R1 trr_valid after reset", trr_valid, 0);
      chk(overflow == 1'b0, "R1 overflow after reset", overflow, 0);
    end
    refresh_expect("R1 R8 empty queue", 0, 1'b0, 0, 1'b0, 0);

    // vector table: R2, R3, R6
    for (int v = 0; v < 5; v++) begin
      avoid_boundary();
      hammer(VECS[v].bank, VECS[v].row, VECS[v].reps);
      refresh_expect($sformatf("vec%0d", v), VECS[v].bank,
                     VECS[v].lo_v, VECS[v].lo, VECS[v].hi_v, VECS[v].hi);
    end

    // R4: same row in every bank, three times each, stays below the trigger
    avoid_boundary();
    for (int b = 0; b < NB; b++) hammer(b, 30, 3);
    refresh_expect("R4 spread over banks", 0, 1'b0, 0, 1'b0, 0);
    hammer(2, 30, 1);
    refresh_expect("R4 bank2 own count", 2, 1'b1, 29, 1'b1, 31);

    // R7 and R8: eight activations queue two pairs, one pair per strobe
    avoid_boundary();
    hammer(1, 50, 8);
    refresh_expect("R7 first trigger", 1, 1'b1, 49, 1'b1, 51);
    refresh_expect("R7 retrigger", 1, 1'b1, 49, 1'b1, 51);
    refresh_expect("R8 one per strobe", 0, 1'b0, 0, 1'b0, 0);

    // R5: counts clear at the window end
    avoid_boundary();
    hammer(3, 5, 3);
    next_window();
    hammer(3, 5, 1);
    refresh_expect("R5 cleared count", 0, 1'b0, 0, 1'b0, 0);
    hammer(3, 5, 3);
    refresh_expect("R5 recount", 3, 1'b1, 4, 1'b1, 6);

    // R10: replacement of the lowest count, bank1 is empty in this window
    hammer(1, 1, 3);
    hammer(1, 2, 3);
    hammer(1, 3, 3);
    hammer(1, 4, 1);
    hammer(1, 5, 1);
    hammer(1, 4, 3);
    refresh_expect("R10 evicted row restarts", 0, 1'b0, 0, 1'b0, 0);
    hammer(1, 1, 1);
    refresh_expect("R10 kept row triggers", 1, 1'b1, 0, 1'b1, 2);

    // R9: queue of two, third aggressor dropped
    avoid_boundary();
    ovf_seen = 1'b0;
    hammer(0, 12, 4);
    hammer(0, 14, 4);
    chk(ovf_seen == 1'b0, "R9 no overflow with room", ovf_seen, 0);
    hammer(0, 16, 4);
    chk(ovf_seen == 1'b1, "R9 overflow on drop", ovf_seen, 1);
    @(negedge clk);
    chk(overflow == 1'b0, "R9 overflow is a pulse", overflow, 0);
    refresh_expect("R9 first kept", 0, 1'b1, 11, 1'b1, 13);
    refresh_expect("R9 second kept", 0, 1'b1, 13, 1'b1, 15);
    refresh_expect("R9 dropped never emitted", 0, 1'b0, 0, 1'b0, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule